// File: doc/BRIEF.md
# Clap sequence command decoder

This block turns short bursts of handclaps into on/off commands for a bank of latched device outputs. Its input is a single-bit flag from an external sound detector, asserted whenever a loud sound is heard. The flag can arrive at any time, so two flip-flops bring it into the clock domain. Each rising edge of the synchronised flag opens a fixed-length shaping window. Only the edge that opens a window counts; edges inside an open window are dropped.

Each accepted pulse adds one to a burst tally and restarts a silence timer. The burst closes when the timer runs out with no new pulse. The block then decodes the final tally. For device d (counting from 0), a tally of 2+2d turns the device on and 3+2d turns it off. With the default of two devices, tallies 2, 3, 4 and 5 drive the four commands. Every other tally is a no-op.

The device latches take the decoded command in the same cycle that a one-cycle result strobe rises. The tally is cleared one cycle later. Two status outputs show whether the block is idle or is inside a burst. The shaping and silence durations are parameters in clock cycles.

Top module: `clap_cmd_decoder`

## Requirements
- R1: While `rst_n` is low at a clock edge, the tally, both timers and every device output are cleared. After reset, `idle_o`=1, `armed_o`=0, `cmd_valid_o`=0 and `dev_o`=0.
- R2: A rising edge of `clap_i` that arrives within SHAPE_CYC cycles of the accepted edge before it is not counted.
- R3: Each accepted pulse adds one to the tally. The tally saturates at 2*N_DEV+2 (6 by default) and never wraps.
- R4: `idle_o`=1 and `armed_o`=0 while the tally is zero. After the first accepted pulse of a burst, `armed_o`=1 and `idle_o`=0, and no command is issued.
- R5: Every accepted pulse restarts the silence timer. Pulses spaced closer than QUIET_CYC cycles stay in one burst. Pulses spaced farther apart form separate bursts.
- R6: A burst closes QUIET_CYC cycles after its last accepted pulse. `cmd_valid_o` is then high for exactly one cycle, and `cmd_count_o` carries the final tally.
- R7: When a burst closes with a tally of 2 it sets `dev_o[0]`, with 3 it clears `dev_o[0]`, with 4 it sets `dev_o[1]` and with 5 it clears `dev_o[1]` (in general, 2+2d sets and 3+2d clears bit d).
- R8: A closing tally of 0, 1, or 2*N_DEV+2 (the saturated value) leaves every device output unchanged.
- R9: Device outputs change only in the cycle when `cmd_valid_o` is high, and each bit holds through bursts that do not address it. The tally returns to zero (`idle_o`=1) in the cycle after `cmd_valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clap_i | input | 1 | Sound-detected flag, asynchronous |
| dev_o | output | N_DEV | Latched device states |
| idle_o | output | 1 | High when the tally is zero |
| armed_o | output | 1 | High while a burst is open |
| cmd_valid_o | output | 1 | One-cycle strobe when a burst closes |
| cmd_count_o | output | CNT_W | Final tally of the closed burst |

## Verification
Take edge k as the first clock edge that samples `clap_i` high. The shaped pulse registers at edge k+2. The tally and `armed_o` change at edge k+3, and the silence timer is loaded at the same edge. The timer's expiry flag rises at edge k+3+QUIET_CYC. `cmd_valid_o`, `cmd_count_o` and `dev_o` change at edge k+4+QUIET_CYC, and `idle_o` returns at edge k+5+QUIET_CYC. The bench counts edges from the negedge where it raises `clap_i`. It samples each output at the falling edge just after the edge where the output is due. It also checks that `cmd_valid_o` is still low one cycle earlier, so a result that comes early or late is caught.

// File: rtl/clap_pkg.sv
// Package: shared helpers for the clap sequence decoder.
// Assumes: device d is addressed by tally 2+2d (set) and 3+2d (clear).
package clap_pkg;

    typedef enum logic [1:0] {
        DEV_KEEP  = 2'd0,
        DEV_SET   = 2'd1,
        DEV_CLEAR = 2'd2
    } dev_cmd_e;

    // Tally that switches device d on.
    function automatic int set_code(input int d);
        return 2 + 2 * d;
    endfunction

    // Tally that switches device d off.
    function automatic int clear_code(input int d);
        return 3 + 2 * d;
    endfunction

    // Command for device d given a closing tally.
    function automatic dev_cmd_e decode_cmd(input int d, input int tally);
        if (tally == set_code(d))        return DEV_SET;
        else if (tally == clear_code(d)) return DEV_CLEAR;
        else                             return DEV_KEEP;
    endfunction

endpackage

// File: rtl/clap_sync_edge.sv
// Module: clap_sync_edge
// Brings the asynchronous sound flag through SYNC_STAGES flip-flops and
// gives a one-cycle (combinational) strobe on its synchronised rising edge.
// Assumes: SYNC_STAGES >= 2.
module clap_sync_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);

    logic [SYNC_STAGES:0] chain_q;

    // Shift the raw flag through the synchroniser plus one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[SYNC_STAGES-1:0], async_i};
    end

    // Rising edge: newest synchronised sample high, the one before low.
    always_comb rise_o = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];

endmodule

// File: rtl/clap_oneshot.sv
// Module: clap_oneshot
// Non-retriggerable pulse shaper. An edge seen while idle gives one
// registered strobe and opens a busy window of SHAPE_CYC cycles. Edges
// inside the window are dropped.
// Assumes: SHAPE_CYC >= 2.
module clap_oneshot #(
    parameter int SHAPE_CYC = 25_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic edge_i,
    output logic shot_o
);

    localparam int SH_W = $clog2(SHAPE_CYC + 1);

    logic            busy_q;
    logic [SH_W-1:0] left_q;

    // Open the window on an accepted edge and count it down to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            left_q <= '0;
            shot_o <= 1'b0;
        end else if (edge_i && !busy_q) begin
            busy_q <= 1'b1;
            left_q <= SH_W'(SHAPE_CYC - 1);
            shot_o <= 1'b1;
        end else begin
            shot_o <= 1'b0;
            if (busy_q) begin
                if (left_q == '0) busy_q <= 1'b0;
                else              left_q <= left_q - 1'b1;
            end
        end
    end

endmodule

// File: rtl/clap_burst_counter.sv
// Module: clap_burst_counter
// Saturating tally of shaped pulses. A clear has priority. A pulse in the
// same cycle as a clear starts the next burst at one.
// Assumes: SAT fits in CNT_W bits.
module clap_burst_counter #(
    parameter int SAT   = 6,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic             clear_i,
    output logic [CNT_W-1:0] count_o
);

    // Count pulses up to SAT. Clear once the burst result has been applied.
    always_ff @(posedge clk) begin
        if (!rst_n)                                count_o <= '0;
        else if (clear_i)                          count_o <= step_i ? CNT_W'(1) : '0;
        else if (step_i && count_o < CNT_W'(SAT))  count_o <= count_o + 1'b1;
    end

endmodule

// File: rtl/clap_quiet_timer.sv
// Module: clap_quiet_timer
// Retriggerable silence timer. Each kick reloads QUIET_CYC. When the count
// runs out, expire_o is high for one cycle.
// Assumes: QUIET_CYC >= 1.
module clap_quiet_timer #(
    parameter int QUIET_CYC = 75_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick_i,
    output logic expire_o
);

    localparam int QT_W = $clog2(QUIET_CYC + 1);

    logic            run_q;
    logic [QT_W-1:0] tmr_q;

    // Reload on a kick and count down. Flag expiry when the count runs out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q    <= 1'b0;
            tmr_q    <= '0;
            expire_o <= 1'b0;
        end else if (kick_i) begin
            run_q    <= 1'b1;
            tmr_q    <= QT_W'(QUIET_CYC);
            expire_o <= 1'b0;
        end else if (run_q && tmr_q == QT_W'(1)) begin
            run_q    <= 1'b0;
            tmr_q    <= '0;
            expire_o <= 1'b1;
        end else begin
            if (run_q) tmr_q <= tmr_q - 1'b1;
            expire_o <= 1'b0;
        end
    end

endmodule

// File: rtl/clap_cmd_latch.sv
// Module: clap_cmd_latch
// Decodes the closing tally and holds one state bit per device. It also
// registers the result strobe and the applied tally.
// Assumes: apply_i is a one-cycle strobe; count_i is stable when it is high.
module clap_cmd_latch #(
    parameter int N_DEV = 2,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             apply_i,
    input  logic [CNT_W-1:0] count_i,
    output logic [N_DEV-1:0] dev_o,
    output logic             valid_o,
    output logic [CNT_W-1:0] count_o
);
    import clap_pkg::*;

    for (genvar d = 0; d < N_DEV; d++) begin : g_dev
        dev_cmd_e cmd;

        // Work out what the closing tally means for this device.
        always_comb cmd = decode_cmd(d, int'(count_i));

        // Hold the device state; change it only on an addressed command.
        always_ff @(posedge clk) begin
            if (!rst_n)                               dev_o[d] <= 1'b0;
            else if (apply_i && cmd == DEV_SET)       dev_o[d] <= 1'b1;
            else if (apply_i && cmd == DEV_CLEAR)     dev_o[d] <= 1'b0;
        end
    end

    // Register the result strobe and the tally it was decoded from.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            count_o <= '0;
        end else begin
            valid_o <= apply_i;
            if (apply_i) count_o <= count_i;
        end
    end

endmodule

// File: rtl/clap_cmd_decoder.sv
// Module: clap_cmd_decoder (top)
// Turns bursts of detected claps into set/clear commands for N_DEV latched
// outputs. Path: synchroniser -> pulse shaper -> tally + silence timer ->
// decode/latch. The tally is cleared one cycle after the latches update.
// Assumes: clap_i is asynchronous; durations are given in clock cycles.
module clap_cmd_decoder #(
    parameter int N_DEV       = 2,
    parameter int SHAPE_CYC   = 25_000_000,
    parameter int QUIET_CYC   = 75_000_000,
    parameter int SYNC_STAGES = 2,
    parameter int SAT_COUNT   = 2 * N_DEV + 2,
    parameter int CNT_W       = $clog2(SAT_COUNT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clap_i,
    output logic [N_DEV-1:0] dev_o,
    output logic             idle_o,
    output logic             armed_o,
    output logic             cmd_valid_o,
    output logic [CNT_W-1:0] cmd_count_o
);

    logic             clap_rise;
    logic             shot_pulse;
    logic             burst_end;
    logic [CNT_W-1:0] tally;

    clap_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(clap_i), .rise_o(clap_rise)
    );

    clap_oneshot #(.SHAPE_CYC(SHAPE_CYC)) u_shape (
        .clk(clk), .rst_n(rst_n), .edge_i(clap_rise), .shot_o(shot_pulse)
    );

    clap_burst_counter #(.SAT(SAT_COUNT), .CNT_W(CNT_W)) u_tally (
        .clk(clk), .rst_n(rst_n), .step_i(shot_pulse),
        .clear_i(cmd_valid_o), .count_o(tally)
    );

    clap_quiet_timer #(.QUIET_CYC(QUIET_CYC)) u_quiet (
        .clk(clk), .rst_n(rst_n), .kick_i(shot_pulse), .expire_o(burst_end)
    );

    clap_cmd_latch #(.N_DEV(N_DEV), .CNT_W(CNT_W)) u_latch (
        .clk(clk), .rst_n(rst_n), .apply_i(burst_end), .count_i(tally),
        .dev_o(dev_o), .valid_o(cmd_valid_o), .count_o(cmd_count_o)
    );

    // Status flags taken from the tally.
    always_comb begin
        idle_o  = (tally == '0);
        armed_o = (tally != '0);
    end

endmodule

// File: rtl/clap_cmd_decoder_chk.sv
// Module: clap_cmd_decoder_chk
// Property checker bound to clap_cmd_decoder. It watches the shaped pulse,
// the tally, the result strobe and the device outputs.
// Assumes: reset is held low for at least two clock edges.
module clap_cmd_decoder_chk #(
    parameter int N_DEV     = 2,
    parameter int SHAPE_CYC = 8,
    parameter int SAT_COUNT = 6,
    parameter int CNT_W     = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             shot_pulse,
    input logic [CNT_W-1:0] tally,
    input logic [N_DEV-1:0] dev_o,
    input logic             cmd_valid_o,
    input logic [CNT_W-1:0] cmd_count_o
);

    int unsigned since_shot;

    // Cycles since the last shaped pulse, saturating at the window length.
    always_ff @(posedge clk) begin
        if (!rst_n)                       since_shot <= SHAPE_CYC;
        else if (shot_pulse)              since_shot <= 1;
        else if (since_shot < SHAPE_CYC)  since_shot <= since_shot + 1;
    end

    a_r2_window_gap: assert property (@(posedge clk) disable iff (!rst_n)
        shot_pulse |-> since_shot >= SHAPE_CYC);

    a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (shot_pulse && !cmd_valid_o && tally < CNT_W'(SAT_COUNT))
        |=> tally == $past(tally) + 1'b1);

    a_r3_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        tally <= CNT_W'(SAT_COUNT));

    a_r6_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |=> !cmd_valid_o);

    a_r8_noop_tally: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && (cmd_count_o < CNT_W'(2) || cmd_count_o == CNT_W'(SAT_COUNT)))
        |-> $stable(dev_o));

    a_r9_change_only_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dev_o) |-> cmd_valid_o);

    a_r9_clear_after: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |=> tally <= CNT_W'(1));

    for (genvar d = 0; d < N_DEV; d++) begin : g_dev_chk
        a_r7_set: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_valid_o && cmd_count_o == CNT_W'(2 + 2 * d)) |-> dev_o[d]);
        a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_valid_o && cmd_count_o == CNT_W'(3 + 2 * d)) |-> !dev_o[d]);
    end

endmodule

bind clap_cmd_decoder clap_cmd_decoder_chk #(
    .N_DEV(N_DEV), .SHAPE_CYC(SHAPE_CYC), .SAT_COUNT(SAT_COUNT), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .shot_pulse(shot_pulse), .tally(tally),
    .dev_o(dev_o), .cmd_valid_o(cmd_valid_o), .cmd_count_o(cmd_count_o)
);

// File: tb/clap_cmd_decoder_test.sv
// Directed bench for clap_cmd_decoder. Each task runs one scenario and
// checks its own results at the falling edge after the clock edge where
// each output is due.
module clap_cmd_decoder_test;

    localparam int N_DEV = 2;
    localparam int SHAPE = 8;
    localparam int QUIET = 40;
    localparam int SATV  = 2 * N_DEV + 2;
    localparam int CW    = $clog2(SATV + 1);

    logic             clk = 1'b0;
    logic             rst_n;
    logic             clap_i;
    logic [N_DEV-1:0] dev_o;
    logic             idle_o, armed_o, cmd_valid_o;
    logic [CW-1:0]    cmd_count_o;

    int n_checks = 0;
    int n_fails  = 0;
    logic [N_DEV-1:0] exp_dev = '0;

    clap_cmd_decoder #(.N_DEV(N_DEV), .SHAPE_CYC(SHAPE), .QUIET_CYC(QUIET)) uut (
        .clk(clk), .rst_n(rst_n), .clap_i(clap_i), .dev_o(dev_o),
        .idle_o(idle_o), .armed_o(armed_o), .cmd_valid_o(cmd_valid_o),
        .cmd_count_o(cmd_count_o)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // Model of the device latches, taken from R7/R8.
    function automatic logic [N_DEV-1:0] model(input logic [N_DEV-1:0] cur, input int tally);
        logic [N_DEV-1:0] nxt = cur;
        for (int d = 0; d < N_DEV; d++) begin
            if (tally == 2 + 2 * d) nxt[d] = 1'b1;
            if (tally == 3 + 2 * d) nxt[d] = 1'b0;
        end
        return nxt;
    endfunction

    // R1: reset state of every output.
    task automatic t_reset();
        rst_n = 1'b0; clap_i = 1'b0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        check(dev_o == '0,      "R1 dev", int'(dev_o), 0);
        check(idle_o == 1'b1,   "R1 idle", int'(idle_o), 1);
        check(armed_o == 1'b0,  "R1 armed", int'(armed_o), 0);
        check(cmd_valid_o == 0, "R1 valid", int'(cmd_valid_o), 0);
        rst_n = 1'b1;
        exp_dev = '0;
    endtask

    // One burst of n claps, spacing edges apart. Checks R4, R6, R7, R8, R9.
    task automatic t_burst(input int n, input int spacing, input string tag);
        int fin = (n < SATV) ? n : SATV;
        for (int i = 0; i < n; i++) begin
            @(negedge clk) clap_i = 1'b1;      // edge k samples it
            @(negedge clk) clap_i = 1'b0;      // after edge k
            repeat (2) @(negedge clk);         // after edge k+2
            if (i == 0) check(idle_o == 1'b1, {"R4 not yet armed ", tag}, int'(idle_o), 1);
            @(negedge clk);                    // after edge k+3
            if (i == 0) begin
                check(armed_o == 1'b1 && idle_o == 1'b0, {"R4 armed ", tag}, int'(armed_o), 1);
                check(cmd_valid_o == 1'b0, {"R4 no command ", tag}, int'(cmd_valid_o), 0);
            end
            if (i != n - 1) repeat (spacing - 4) @(negedge clk);
        end
        repeat (QUIET) @(negedge clk);         // after edge k+3+QUIET
        check(cmd_valid_o == 1'b0, {"R6 not early ", tag}, int'(cmd_valid_o), 0);
        @(negedge clk);                        // after edge k+4+QUIET
        exp_dev = model(exp_dev, fin);
        check(cmd_valid_o == 1'b1, {"R6 strobe ", tag}, int'(cmd_valid_o), 1);
        check(int'(cmd_count_o) == fin, {"R3 R6 tally ", tag}, int'(cmd_count_o), fin);
        check(dev_o == exp_dev, {"R7 R8 R9 devices ", tag}, int'(dev_o), int'(exp_dev));
        @(negedge clk);                        // after edge k+5+QUIET
        check(cmd_valid_o == 1'b0, {"R6 one cycle ", tag}, int'(cmd_valid_o), 0);
        check(idle_o == 1'b1, {"R9 cleared ", tag}, int'(idle_o), 1);
        repeat (4) @(negedge clk);
    endtask

    // R2: a second edge inside the shaping window is not counted.
    task automatic t_bounce();
        bit seen = 0;
        @(negedge clk) clap_i = 1'b1;
        @(negedge clk) clap_i = 1'b0;
        @(negedge clk) clap_i = 1'b1;
        repeat (2) @(negedge clk);
        clap_i = 1'b0;
        for (int c = 0; c < QUIET + 20 && !seen; c++) begin
            @(negedge clk);
            if (cmd_valid_o) begin
                seen = 1;
                check(int'(cmd_count_o) == 1, "R2 bounce counted once", int'(cmd_count_o), 1);
                check(dev_o == exp_dev, "R2 R8 devices held", int'(dev_o), int'(exp_dev));
            end
        end
        check(seen, "R2 burst closed", int'(seen), 1);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        t_reset();
        t_burst(2, 12, "two");            // dev0 on
        t_burst(4, 12, "four");           // dev1 on, dev0 holds
        t_burst(3, 35, "three spaced");   // R5 retrigger; dev0 off
        t_burst(1, 12, "one");            // R8 no-op
        t_burst(1, 12, "gap one");        // R5 gaps over QUIET split bursts
        t_burst(7, 12, "seven");          // R3 saturation, R8 no-op
        t_burst(5, 12, "five");           // dev1 off
        t_burst(2, 12, "two again");
        t_bounce();
        t_reset();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule